// File: doc/BRIEF.md
# Write-Once-Lockable Serial Number Register Bank

This block stores a 64-bit serial number as eight byte-wide registers on a simple register bus. Each access presents an address. A write is flagged by a write enable and carries a byte of write data. Until the bank is locked, the eight bytes behave as ordinary read/write storage. They may be rewritten as often as software likes, so they can also serve as general-purpose scratch bytes.

A companion control register holds a one-way lock flag. Writing a 1 to that flag write-protects the serial bytes for the rest of operation. No later write can return the flag to 0. After locking, the serial bytes still read back normally. Writes to them finish on the bus as usual, with no error indication, and leave the stored data unchanged. The remaining bits of the control register stay freely writable.

The bus has no handshake. An access is accepted every cycle. Read data is registered: `rd_data` shows the contents of the address that was presented at the previous rising edge. The value returned is the one held before any write made at that same edge. Reset clears every register. This is done for simulation convenience.

Top module: `sn_lock_bank`

## Requirements
- R1: After reset, all eight serial bytes and the whole control register read as 0, and `rd_data` is 0.
- R2: While the lock flag is 0, a write to address 8'h10+i (i = 0..7) stores `wr_data` in serial byte i. A read of that address then returns the stored byte.
- R3: While unlocked, a serial byte can be rewritten any number of times. A read returns the most recent write.
- R4: A write to the control register (address 8'h18) with bit 7 of `wr_data` set to 1 sets the lock flag. Reads of address 8'h18 show the lock flag in bit 7.
- R5: While the lock flag is 1, writes to addresses 8'h10 through 8'h17 leave every serial byte unchanged.
- R6: Once set, the lock flag stays 1, whatever value later writes to address 8'h18 carry in bit 7.
- R7: Bits 6:0 of the control register take the value written to address 8'h18, both before and after locking.
- R8: Serial bytes read back their stored values while the bank is locked.
- R9: Any address outside 8'h10 to 8'h18 reads as 0. A write to such an address changes no register.
- R10: `rd_data` in the cycle after edge n equals the contents, before any write at edge n, of the address sampled at edge n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Register address of the current access |
| wr_en | input | 1 | Write strobe for the current access |
| wr_data | input | 8 | Byte to be written |
| rd_data | output | 8 | Registered read data for the address sampled at the previous edge |

## Verification
A distinct byte is written to every serial address and read back. This separates the per-byte selects, so a swapped or shared byte register shows up. The same byte is then rewritten with two values in a row, and the last one must win. Writes of all-ones to every serial address after locking, alongside writes of 0 to bit 7 of the control register, set the stickiness of the lock apart from the freedom of the lower control bits. Unmapped writes and a read issued in the same cycle as a write check address decoding and the read-before-write timing of the registered read path.

// File: rtl/sn_lock_pkg.sv
package sn_lock_pkg;

  // Which part of the bank an address falls in.
  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_SN   = 2'd1,
    RGN_CTRL = 2'd2
  } region_e;

endpackage

// File: rtl/sn_addr_decode.sv
module sn_addr_decode
  import sn_lock_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter int                SN_BYTES  = 8,
  parameter logic [ADDR_W-1:0] SN_BASE   = 8'h10,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h18
) (
  input  logic [ADDR_W-1:0]   addr,
  output logic [SN_BYTES-1:0] sn_sel,
  output logic                ctrl_sel,
  output region_e             region
);

  for (genvar i = 0; i < SN_BYTES; i++) begin : g_sel
    assign sn_sel[i] = (addr == ADDR_W'(SN_BASE + i));
  end

  assign ctrl_sel = (addr == CTRL_ADDR);

  always_comb begin
    if (ctrl_sel)     region = RGN_CTRL;
    else if (|sn_sel) region = RGN_SN;
    else              region = RGN_NONE;
  end

  // At most one byte select per address.
  always_comb begin
    assert ($onehot0(sn_sel));
  end

endmodule

// File: rtl/sn_byte_bank.sv
module sn_byte_bank #(
  parameter int SN_BYTES = 8,
  parameter int DATA_W   = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [SN_BYTES-1:0]              sn_sel,
  input  logic [DATA_W-1:0]                wr_data,
  input  logic                             locked,
  output logic [SN_BYTES-1:0][DATA_W-1:0]  sn_bytes
);

  for (genvar i = 0; i < SN_BYTES; i++) begin : g_byte
    logic byte_we;
    assign byte_we = wr_en && sn_sel[i] && !locked;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sn_bytes[i] <= '0;
      else if (byte_we) sn_bytes[i] <= wr_data;
    end

    AST_UNLOCKED_WRITE_STORES: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sn_sel[i] && !locked) |=> (sn_bytes[i] == $past(wr_data))); // R2

    AST_LOCKED_BYTE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> $stable(sn_bytes[i])); // R5

    AST_UNSELECTED_BYTE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && sn_sel[i]) |=> $stable(sn_bytes[i])); // R9
  end

endmodule

// File: rtl/sn_lock_ctrl.sv
module sn_lock_ctrl #(
  parameter int DATA_W   = 8,
  parameter int LOCK_BIT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              ctrl_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] ctrl_q,
  output logic              locked
);

  localparam logic [DATA_W-1:0] LOCK_MASK = DATA_W'(1) << LOCK_BIT;

  logic [DATA_W-1:0] ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en && ctrl_sel) begin
      // Free bits follow the write; the lock bit can only be raised.
      ctrl_d = (wr_data & ~LOCK_MASK) | (ctrl_q & LOCK_MASK) | (wr_data & LOCK_MASK);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assign locked = ctrl_q[LOCK_BIT];

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked); // R6

  AST_LOCK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ctrl_sel && wr_data[LOCK_BIT]) |=> locked); // R4

  AST_FREE_BITS_WRITABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ctrl_sel) |=> ((ctrl_q & ~LOCK_MASK) == ($past(wr_data) & ~LOCK_MASK))); // R7

endmodule

// File: rtl/sn_read_mux.sv
module sn_read_mux
  import sn_lock_pkg::*;
#(
  parameter int SN_BYTES = 8,
  parameter int DATA_W   = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  region_e                          region,
  input  logic [SN_BYTES-1:0]              sn_sel,
  input  logic [SN_BYTES-1:0][DATA_W-1:0]  sn_bytes,
  input  logic [DATA_W-1:0]                ctrl_q,
  output logic [DATA_W-1:0]                rd_data
);

  logic [DATA_W-1:0] sn_pick;
  logic [DATA_W-1:0] rd_next;

  always_comb begin
    sn_pick = '0;
    for (int i = 0; i < SN_BYTES; i++) begin
      sn_pick |= sn_bytes[i] & {DATA_W{sn_sel[i]}};
    end
  end

  always_comb begin
    unique case (region)
      RGN_SN:   rd_next = sn_pick;
      RGN_CTRL: rd_next = ctrl_q;
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= rd_next;
  end

  AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (region == RGN_NONE) |=> (rd_data == '0)); // R9

  AST_CTRL_READ_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    (region == RGN_CTRL) |=> (rd_data == $past(ctrl_q))); // R10

endmodule

// File: rtl/sn_lock_bank.sv
module sn_lock_bank
  import sn_lock_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter int                DATA_W    = 8,
  parameter int                SN_BYTES  = 8,
  parameter logic [ADDR_W-1:0] SN_BASE   = 8'h10,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h18,
  parameter int                LOCK_BIT  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);

  logic [SN_BYTES-1:0]             sn_sel;
  logic                            ctrl_sel;
  region_e                         region;
  logic [SN_BYTES-1:0][DATA_W-1:0] sn_bytes;
  logic [DATA_W-1:0]               ctrl_q;
  logic                            locked;

  sn_addr_decode #(
    .ADDR_W(ADDR_W), .SN_BYTES(SN_BYTES), .SN_BASE(SN_BASE), .CTRL_ADDR(CTRL_ADDR)
  ) u_decode (
    .addr(addr), .sn_sel(sn_sel), .ctrl_sel(ctrl_sel), .region(region)
  );

  sn_byte_bank #(.SN_BYTES(SN_BYTES), .DATA_W(DATA_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sn_sel(sn_sel),
    .wr_data(wr_data), .locked(locked), .sn_bytes(sn_bytes)
  );

  sn_lock_ctrl #(.DATA_W(DATA_W), .LOCK_BIT(LOCK_BIT)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ctrl_sel(ctrl_sel),
    .wr_data(wr_data), .ctrl_q(ctrl_q), .locked(locked)
  );

  sn_read_mux #(.SN_BYTES(SN_BYTES), .DATA_W(DATA_W)) u_rmux (
    .clk(clk), .rst_n(rst_n), .region(region), .sn_sel(sn_sel),
    .sn_bytes(sn_bytes), .ctrl_q(ctrl_q), .rd_data(rd_data)
  );

  AST_RESET_READ_ZERO: assert property (@(posedge clk)
    $rose(rst_n) |-> (rd_data == '0)); // R1

endmodule

// File: tb/sn_lock_bank_tb.sv
module sn_lock_bank_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = 8'h00;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;

  always #10 clk = ~clk;

  sn_lock_bank u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data)
  );

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t scb_q[$];
  logic  rd_mark = 1'b0;
  int    n_checks = 0;
  int    n_fail = 0;
  bit    done = 1'b0;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1; rd_mark = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    addr = a; wr_en = 1'b0; rd_mark = 1'b1;
    it.exp = exp; it.tag = tag;
    scb_q.push_back(it);
  endtask

  // Write and read in the same cycle: the read sees the old contents.
  task automatic wrrd(input logic [7:0] a, input logic [7:0] d,
                      input logic [7:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1; rd_mark = 1'b1;
    it.exp = exp; it.tag = tag;
    scb_q.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
    wr_en = 1'b0; rd_mark = 1'b0;
  endtask

  // Monitor: a read marked at an edge is compared after that edge.
  initial begin
    forever begin
      logic m;
      @(posedge clk);
      m = rd_mark;
      #5;
      if (m) begin
        item_t it;
        if (scb_q.size() == 0) begin
          check("scoreboard underflow", rd_data, 8'hxx);
        end else begin
          it = scb_q.pop_front();
          check(it.tag, rd_data, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  logic [7:0] sn_val [8];

  initial begin
    repeat (3) @(posedge clk);
    #3;
    check("R1 rd_data in reset", rd_data, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < 8; i++) rd(8'h10 + 8'(i), 8'h00, "R1 serial byte after reset");
    rd(8'h18, 8'h00, "R1 control after reset");

    for (int i = 0; i < 8; i++) wr(8'h10 + 8'(i), 8'hA0 + 8'(i * 17));
    for (int i = 0; i < 8; i++) rd(8'h10 + 8'(i), 8'hA0 + 8'(i * 17), "R2 byte stored");

    wr(8'h13, 8'h5A);
    rd(8'h13, 8'h5A, "R3 first rewrite");
    wr(8'h13, 8'hC3);
    wr(8'h13, 8'h3C);
    rd(8'h13, 8'h3C, "R3 last rewrite wins");

    for (int i = 0; i < 8; i++) begin
      sn_val[i] = 8'h21 + 8'(i * 29);
      wr(8'h10 + 8'(i), sn_val[i]);
    end

    wr(8'h18, 8'h25);
    rd(8'h18, 8'h25, "R7 free bits before lock");

    wr(8'h19, 8'hFF);
    wr(8'h0F, 8'hFF);
    wr(8'h00, 8'hFF);
    rd(8'h19, 8'h00, "R9 unmapped above");
    rd(8'h0F, 8'h00, "R9 unmapped below");
    rd(8'h10, sn_val[0], "R9 byte 0 untouched");
    rd(8'h17, sn_val[7], "R9 byte 7 untouched");
    rd(8'h18, 8'h25, "R9 control untouched");

    wrrd(8'h14, 8'h77, sn_val[4], "R10 read before write");
    sn_val[4] = 8'h77;
    rd(8'h14, 8'h77, "R10 write visible next");

    wr(8'h18, 8'h91);
    rd(8'h18, 8'h91, "R4 lock flag set");

    for (int i = 0; i < 8; i++) wr(8'h10 + 8'(i), 8'hFF);
    for (int i = 0; i < 8; i++) rd(8'h10 + 8'(i), sn_val[i], "R5 R8 locked byte unchanged");
    wrrd(8'h12, 8'h00, sn_val[2], "R5 locked same-cycle");
    rd(8'h12, sn_val[2], "R5 locked after write");

    wr(8'h18, 8'h03);
    rd(8'h18, 8'h83, "R6 R7 lock kept, free bits written");
    wr(8'h18, 8'h00);
    rd(8'h18, 8'h80, "R6 lock survives zero write");
    wr(8'h18, 8'hFF);
    rd(8'h18, 8'hFF, "R7 free bits after lock");

    idle();
    idle();
    idle();
    if (scb_q.size() != 0) check("scoreboard drained", 8'(scb_q.size()), 8'h00);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule